// File: doc/BRIEF.md
# Serial Register Access Slave

This block gives a host access to a bank of byte-wide configuration registers over a four-wire serial port. The wires are an active-low select, a serial clock, a data input and a data output. Each access is one fixed 16-bit frame. The frame holds a read/write flag, a 6-bit register address sent least significant bit first, one unused gap bit, and an 8-bit data field, also sent least significant bit first. A write takes effect only after the whole frame has arrived. A read returns the addressed byte on the serial output during the data field. The output enable pin tells the pad when to drive; while the enable is low the pad is high-impedance.

The port pins are oversampled on a fast system clock. Each pin passes through a two-flop synchronizer, and the serial clock edges are found by comparing the synchronized samples. The bank holds three kinds of location:
- a run of plain configuration registers that have computed defaults;
- a sticky status register that hardware events set and the host clears by writing ones;
- a mask register, which combines with the status register to drive an active-low interrupt.

A separate hardware reset pin restores every default value. It acts only after a long, qualified low level, measured in system clock cycles. Shorter low pulses are ignored.

Top module: `ser_cfg_slave`

## Requirements
- R1: A frame starts when the synchronized select goes low. Its bits are counted on serial clock rising edges, and the count stops at 16 until the select returns high.
- R2: Data input is sampled on serial clock rising edges. Frame position 1 is the access flag (1 = read, 0 = write). Positions 2 to 7 carry address bits 0 to 5. Position 8 is ignored. Positions 9 to 16 carry data bits 0 to 7.
- R3: A write changes its target register only after the 16th rising edge. A frame cut short by the select rising early leaves every register unchanged.
- R4: During a read, data bit k is driven on the serial clock falling edge that follows rising edge 8+k, for k = 0 to 7. The output enable is high only for those bits; in every other frame position, and while the select is high, it is low.
- R5: Bits clocked after the 16th within one select-low period are ignored. A second access needs the select to rise and fall again.
- R6: Addresses 0 to NUM_CFG-1 are read/write registers, and register a resets to DEF_SEED XOR a. Every other address outside STAT_ADDR and MASK_ADDR reads 0 and ignores writes.
- R7: A low level on the hardware reset pin restores all register defaults once it lasts RST_CYCLES+1 synchronized clock cycles. A low level of RST_CYCLES cycles or fewer changes nothing.
- R8: Status bits at STAT_ADDR are set by the evt_i inputs and cleared by writing 1 to them. If an event and a clear hit the same bit in the same cycle, the event wins. The mask at MASK_ADDR resets to 0. The output irq_n_o is low exactly when status AND mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| hw_rst_n_i | input | 1 | Filtered default-restore pin, active low |
| evt_i | input | 8 | Status event pulses, one per status bit |
| sdo_o | output | 1 | Serial read data |
| sdo_en_o | output | 1 | Pad drive enable for sdo_o (low = high-Z) |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
Directed writes and reads use distinct bit patterns in every address and data position. A byte-reversal or a swap between the address and data fields therefore shows up as a wrong readback. A frame cut off after 12 bits and a frame that runs 16 bits past the end separate commit-on-completion from commit-per-bit and from commit-on-select-rise. Seeded random read and write traffic, biased toward implemented locations but reaching unmapped ones too, is compared against a bench model of the bank. Reset pulses just below and well above the threshold, together with masked and unmasked status events, separate the qualified reset and the interrupt gating from simpler level logic.

// File: rtl/ser_cfg_slave.sv
module ser_cfg_slave #(
  parameter int          NUM_CFG    = 16,
  parameter logic [7:0]  DEF_SEED   = 8'hA5,
  parameter logic [5:0]  STAT_ADDR  = 6'h3E,
  parameter logic [5:0]  MASK_ADDR  = 6'h3F,
  parameter int          RST_CYCLES = 2_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic       sclk_i,
  input  logic       sdi_i,
  input  logic       hw_rst_n_i,
  input  logic [7:0] evt_i,
  output logic       sdo_o,
  output logic       sdo_en_o,
  output logic       irq_n_o
);

  localparam int AW  = $clog2(NUM_CFG);
  localparam int RCW = $clog2(RST_CYCLES + 1);

  logic [1:0] cs_q, sclk_q, sdi_q, hrst_q;
  logic       sclk_d;
  logic       cs_s, sdi_s, hrst_s, rise, fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q   <= 2'b11;
      sclk_q <= 2'b00;
      sdi_q  <= 2'b00;
      hrst_q <= 2'b11;
      sclk_d <= 1'b0;
    end else begin
      cs_q   <= {cs_q[0], cs_n_i};
      sclk_q <= {sclk_q[0], sclk_i};
      sdi_q  <= {sdi_q[0], sdi_i};
      hrst_q <= {hrst_q[0], hw_rst_n_i};
      sclk_d <= sclk_q[1];
    end

  assign cs_s   = cs_q[1];
  assign sdi_s  = sdi_q[1];
  assign hrst_s = hrst_q[1];
  assign rise   = sclk_q[1] & ~sclk_d & ~cs_s;
  assign fall   = ~sclk_q[1] & sclk_d & ~cs_s;

  // frame capture
  logic [4:0] cnt;
  logic       rw_q;
  logic [5:0] addr_q;
  logic [7:0] dat_q;
  logic       wr_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
      dat_q   <= '0;
      wr_pend <= 1'b0;
    end else begin
      wr_pend <= rise && cnt == 5'd15 && !rw_q;
      if (cs_s) cnt <= '0;
      else if (rise && cnt != 5'd16) begin
        cnt <= cnt + 5'd1;
        if (cnt == 5'd0) rw_q <= sdi_s;
        else if (cnt <= 5'd6) addr_q[cnt[2:0] - 3'd1] <= sdi_s;
        else if (cnt >= 5'd8) dat_q[cnt[2:0]] <= sdi_s;
      end
    end

  // filtered default restore
  logic [RCW-1:0] rcnt;
  logic           rst_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rcnt <= '0;
    else if (hrst_s) rcnt <= '0;
    else if (rcnt != RCW'(RST_CYCLES)) rcnt <= rcnt + 1'b1;

  assign rst_hit = !hrst_s && rcnt == RCW'(RST_CYCLES);

  // register bank
  logic [NUM_CFG-1:0][7:0] cfg;
  logic [7:0] status, mask;
  logic       in_cfg;
  logic [7:0] clr, rd_val;

  assign in_cfg = int'(addr_q) < NUM_CFG;
  assign clr    = (wr_pend && addr_q == STAT_ADDR) ? dat_q : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || rst_hit) begin
      for (int i = 0; i < NUM_CFG; i++) cfg[i] <= DEF_SEED ^ 8'(i);
      status <= '0;
      mask   <= '0;
    end else begin
      if (wr_pend && in_cfg) cfg[addr_q[AW-1:0]] <= dat_q;
      if (wr_pend && addr_q == MASK_ADDR) mask <= dat_q;
      status <= (status & ~clr) | evt_i;
    end

  always_comb begin
    rd_val = 8'h00;
    if (in_cfg) rd_val = cfg[addr_q[AW-1:0]];
    else if (addr_q == STAT_ADDR) rd_val = status;
    else if (addr_q == MASK_ADDR) rd_val = mask;
  end

  assign irq_n_o = ~|(status & mask);

  // read launch
  logic [7:0] rd_sh;
  logic       sdo_q, oe_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_sh <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      if (rise && cnt == 5'd7) rd_sh <= rd_val;
      if (cs_s) oe_q <= 1'b0;
      else if (fall) begin
        if (rw_q && cnt[4:3] == 2'b01) begin
          sdo_q <= rd_sh[0];
          rd_sh <= {1'b0, rd_sh[7:1]};
          oe_q  <= 1'b1;
        end else oe_q <= 1'b0;
      end
    end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = oe_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cnt == 5'd16 && !cs_s) |=> (cnt == 5'd16 || $past(cs_s) || cs_s)); // R1
  AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) (!$past(rise && cnt == 5'd15) && !rst_hit) |=> ($stable(cfg) && $stable(mask))); // R3
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (cs_s && $past(cs_s)) |-> !sdo_en_o); // R4
  AST_PAST_END: assert property (@(posedge clk) disable iff (!rst_n) (rise && cnt == 5'd16) |=> ($stable(dat_q) && $stable(addr_q) && $stable(rw_q))); // R5
  AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_hit) |-> (cfg[0] == DEF_SEED && mask == 8'h00 && irq_n_o)); // R7
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n) (|(evt_i & mask) && !rst_hit && !wr_pend) |=> !irq_n_o); // R8

endmodule

// File: tb/test_ser_cfg_slave.sv
module test_ser_cfg_slave;
  localparam int  NCFG = 16;
  localparam logic [7:0] SEED = 8'hA5;
  localparam logic [5:0] STA = 6'h3E;
  localparam logic [5:0] MSK = 6'h3F;
  localparam int  RSTC = 60;
  localparam int  HP   = 6;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0, hw_rst_n = 1;
  logic [7:0] evt = 0;
  logic sdo, sdo_en, irq_n;
  int checks = 0, errors = 0;
  bit done = 0, en_bad;
  logic [7:0] expm [64];

  always #2.5 clk = ~clk;

  ser_cfg_slave #(.NUM_CFG(NCFG), .DEF_SEED(SEED), .STAT_ADDR(STA), .MASK_ADDR(MSK), .RST_CYCLES(RSTC))
    i_ser_cfg_slave (.clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
                     .hw_rst_n_i(hw_rst_n), .evt_i(evt), .sdo_o(sdo), .sdo_en_o(sdo_en), .irq_n_o(irq_n));

  function automatic logic [7:0] def_of(input int a);
    if (a < NCFG) return SEED ^ 8'(a);
    return 8'h00;
  endfunction

  function automatic void model_defaults();
    for (int a = 0; a < 64; a++) expm[a] = def_of(a);
  endfunction

  function automatic void model_write(input logic [5:0] a, input logic [7:0] d);
    if (int'(a) < NCFG || a == MSK) expm[a] = d;
    else if (a == STA) expm[a] = expm[a] & ~d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic rw, input logic [5:0] a, input logic [7:0] d,
                      input int nbits, input logic [7:0] d2, output logic [7:0] rd);
    logic [15:0] v1, v2;
    v1 = {d, 1'b0, a, rw};
    v2 = {d2, 1'b0, a, rw};
    rd = 8'h00;
    en_bad = 0;
    cs_n = 0;
    tick(HP);
    for (int i = 0; i < nbits; i++) begin
      sclk = 0;
      sdi = (i < 16) ? v1[i] : v2[i - 16];
      tick(HP);
      if (rw && i >= 8 && i < 16) begin
        rd[i - 8] = sdo;
        if (!sdo_en) en_bad = 1;
      end else if (sdo_en) en_bad = 1;
      sclk = 1;
      tick(HP);
    end
    sclk = 0;
    tick(HP);
    cs_n = 1;
    tick(HP);
    if (sdo_en) en_bad = 1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] r;
    xfer(1'b0, a, d, 16, 8'h00, r);
    model_write(a, d);
  endtask

  task automatic rd_chk(input logic [5:0] a, input string req);
    logic [7:0] r;
    xfer(1'b1, a, 8'h00, 16, 8'h00, r);
    chk(r == expm[a], req, r, expm[a]);
    chk(!en_bad, "R4 output enable window", 8'(en_bad), 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h01, 8'h00);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd7321));
    model_defaults();
    tick(4);
    rst_n = 1;
    tick(4);
    // reset state
    chk(irq_n == 1'b1, "R8 irq idle after reset", 8'(irq_n), 8'h01);
    chk(sdo_en == 1'b0, "R4 enable low after reset", 8'(sdo_en), 8'h00);
    rd_chk(6'd0, "R6 default addr 0");
    rd_chk(6'd15, "R6 default addr 15");
    rd_chk(MSK, "R8 mask default");
    rd_chk(STA, "R8 status default");
    rd_chk(6'd40, "R6 unmapped reads zero");
    // directed writes with asymmetric patterns
    wr(6'd1, 8'h01);
    wr(6'd14, 8'h80);
    wr(6'd9, 8'h3C);
    rd_chk(6'd1, "R2 data lsb first");
    rd_chk(6'd14, "R2 address order");
    rd_chk(6'd9, "R2 mixed pattern");
    rd_chk(6'd6, "R2 neighbour untouched");
    wr(6'd20, 8'hFF);
    rd_chk(6'd20, "R6 unmapped write ignored");
    // frame cut short
    xfer(1'b0, 6'd5, 8'h5A, 12, 8'h00, r);
    rd_chk(6'd5, "R3 short frame no commit");
    xfer(1'b0, 6'd5, 8'h5A, 15, 8'h00, r);
    rd_chk(6'd5, "R3 fifteen bits no commit");
    // over-long frame: second frame ignored
    xfer(1'b0, 6'd7, 8'h96, 32, 8'h69, r);
    model_write(6'd7, 8'h96);
    rd_chk(6'd7, "R5 extra bits ignored");
    xfer(1'b1, 6'd7, 8'h00, 32, 8'h00, r);
    chk(r == 8'h96, "R5 overlong read data", r, 8'h96);
    chk(!en_bad, "R5 R4 enable off after bit 16", 8'(en_bad), 8'h00);
    // random traffic
    for (int n = 0; n < 40; n++) begin
      logic [5:0] a;
      logic [7:0] d;
      int sel;
      sel = $urandom % 4;
      if (sel < 2) a = 6'($urandom % NCFG);
      else if (sel == 2) a = ($urandom % 2) ? MSK : STA;
      else a = 6'($urandom);
      d = 8'($urandom);
      if ($urandom % 2) wr(a, d);
      else rd_chk(a, "R1 R2 R6 random access");
    end
    // interrupt
    wr(MSK, 8'h01);
    wr(STA, 8'hFF);
    tick(2);
    evt = 8'h02;
    tick(1);
    evt = 8'h00;
    tick(3);
    chk(irq_n == 1'b1, "R8 masked event no irq", 8'(irq_n), 8'h01);
    expm[STA] = 8'h02;
    rd_chk(STA, "R8 status sticky");
    evt = 8'h01;
    tick(1);
    evt = 8'h00;
    tick(3);
    chk(irq_n == 1'b0, "R8 unmasked event irq", 8'(irq_n), 8'h00);
    expm[STA] = 8'h03;
    wr(STA, 8'h02);
    chk(irq_n == 1'b0, "R8 clearing other bit keeps irq", 8'(irq_n), 8'h00);
    wr(STA, 8'h01);
    chk(irq_n == 1'b1, "R8 write one clears irq", 8'(irq_n), 8'h01);
    // hardware reset filter
    wr(6'd3, 8'hC3);
    evt = 8'h01;
    tick(1);
    evt = 8'h00;
    tick(3);
    expm[STA] = expm[STA] | 8'h01;
    hw_rst_n = 0;
    tick(40);
    hw_rst_n = 1;
    tick(6);
    chk(irq_n == 1'b0, "R7 short pulse keeps irq", 8'(irq_n), 8'h00);
    rd_chk(6'd3, "R7 short pulse ignored");
    hw_rst_n = 0;
    tick(RSTC - 2);
    hw_rst_n = 1;
    tick(6);
    rd_chk(6'd3, "R7 pulse just under threshold ignored");
    hw_rst_n = 0;
    tick(90);
    hw_rst_n = 1;
    tick(6);
    model_defaults();
    chk(irq_n == 1'b1, "R7 long pulse clears irq", 8'(irq_n), 8'h01);
    rd_chk(6'd3, "R7 default restored");
    rd_chk(6'd9, "R7 default restored second");
    rd_chk(MSK, "R7 mask restored");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule